// File: doc/BRIEF.md
# Trace Port Frame Deformatter

The deformatter takes the byte stream from a trace port that interleaves several trace sources. It recovers the stream of one chosen source. Bytes enter on a valid/data pair. A four-byte synchronization pattern, `FF FF FF 7F`, fixes the frame alignment. The block then collects sixteen-byte frames and decodes each complete frame into data bytes. Each data byte belongs to the source that was current at its position. Only bytes of the source named by `stream_sel` leave on the output valid/data pair. The current source ID is also driven out.

In a frame, position 15 holds an auxiliary byte. Each even position carries either a 7-bit source ID (LSB set) or a data byte whose LSB was given up for that marker. The lost bit sits in the auxiliary byte. An ID change can apply at once, or it can wait until the odd data byte that follows. After reset, a programmable number of input bytes can be dropped so that alignment can be forced without a sync pattern.

The block has three pipeline stages:

- The alignment stage counts off the skipped bytes and watches for the sync pattern. It holds back the three most recent bytes, so a pattern can be removed whole.
- The frame stage counts positions and hands each completed frame to a second buffer.
- The walker state machine steps through that buffer one position per cycle. Its states are `W_IDLE`, `W_EVEN` and `W_ODD`. The transitions are:
  - frame ready: `W_IDLE` to `W_EVEN`
  - next odd position: `W_EVEN` to `W_ODD`
  - next even position: `W_ODD` to `W_EVEN`
  - last even position (14) done: `W_EVEN` to `W_IDLE`

Because of the hold-back, the last three bytes of a frame are passed on only when three more bytes arrive. A trailing sync pattern is the normal way to flush them.

Top module: `trace_deformatter`

## Requirements
- R1: After reset `out_valid` is 0 and `cur_stream` is 0; ID 0 means "no source".
- R2: The first `skip_count` input bytes after reset are discarded before any sync matching or frame assembly.
- R3: Four consecutive input bytes `FF FF FF 7F` form a sync pattern. The partial frame is discarded, and the next byte is frame position 0.
- R4: Sync matching runs on every input byte regardless of frame position, including when the pattern straddles a frame boundary. No byte of a sync pattern is ever output.
- R5: A frame is 16 bytes. Position 15 is the auxiliary byte, and its bit k belongs to even position 2k (k = 0..7).
- R6: An even-position byte with bit 0 = 1 is an ID byte, and the new source ID is bits 7:1. With its auxiliary bit 0 the change takes effect at that position.
- R7: An even-position byte with bit 0 = 0 is data. It is output as bits 7:1 with bit 0 taken from its auxiliary bit.
- R8: An ID byte whose auxiliary bit is 1 changes the ID only after the following odd-position byte has been attributed to the old ID. For position 14 the change takes effect at the end of the frame.
- R9: Odd positions 1 to 13 are always data and are output unchanged.
- R10: A data byte is output only when the current source ID equals `stream_sel` and is not 0. Output bytes keep their position order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input trace byte |
| skip_count | input | SKIP_W (8) | Bytes to drop after reset |
| stream_sel | input | 7 | Source ID to pass through |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Recovered data byte |
| cur_stream | output | 7 | Source ID currently in force |

## Verification
A wrong frame position or a missed sync shows up within one frame, as extra bytes or as bytes out of order at the output. The scoreboard catches both on the first mismatching byte. A wrong source ID shows up as whole runs of missing or extra bytes from the next data position on. This includes an ID change applied one byte too early or too late, which moves exactly the byte next to the ID byte across the boundary. A wrongly restored auxiliary bit flips bit 0 of a single even-position byte.

// File: rtl/tdf_pkg.sv
package tdf_pkg;
    localparam int FRAME_BYTES = 16;
    localparam int ID_W        = 7;
    localparam int HOLD_BYTES  = 3;
    localparam logic [7:0] SYNC_HEAD = 8'hFF;
    localparam logic [7:0] SYNC_TAIL = 8'h7F;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_EVEN = 2'd1,
        W_ODD  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/tdf_align.sv
module tdf_align
    import tdf_pkg::*;
#(
    parameter int SKIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [SKIP_W-1:0] skip_count,
    output logic              pop_valid,
    output logic [7:0]        pop_byte,
    output logic              sync_q
);
    localparam int CW = $clog2(HOLD_BYTES + 1);

    logic [SKIP_W-1:0]                skip_seen;
    logic [HOLD_BYTES-1:0][7:0]       hold;
    logic [CW-1:0]                    fill;
    logic                             skipping, take, head_ok, sync_hit;

    assign skipping = (skip_seen != skip_count);
    assign take     = in_valid && !skipping;

    always_comb begin
        head_ok = (fill == CW'(HOLD_BYTES));
        for (int i = 0; i < HOLD_BYTES; i++) begin
            if (hold[i] != SYNC_HEAD) head_ok = 1'b0;
        end
    end
    assign sync_hit = take && head_ok && (in_byte == SYNC_TAIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_seen <= '0;
            hold      <= '0;
            fill      <= '0;
            pop_valid <= 1'b0;
            pop_byte  <= '0;
            sync_q    <= 1'b0;
        end else begin
            pop_valid <= 1'b0;
            sync_q    <= sync_hit;
            if (in_valid && skipping) skip_seen <= skip_seen + 1'b1;
            if (sync_hit) begin
                fill <= '0;
            end else if (take) begin
                if (fill == CW'(HOLD_BYTES)) begin
                    pop_valid <= 1'b1;
                    pop_byte  <= hold[HOLD_BYTES-1];
                end else begin
                    fill <= fill + 1'b1;
                end
                hold <= {hold[HOLD_BYTES-2:0], in_byte};
            end
        end
    end

    p_skip_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && skipping) |=> !pop_valid);
    p_sync_no_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> !pop_valid);
endmodule

// File: rtl/tdf_frame.sv
module tdf_frame
    import tdf_pkg::*;
#(
    parameter int NB = FRAME_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pop_valid,
    input  logic [7:0]          pop_byte,
    input  logic                sync_q,
    output logic                frm_valid,
    output logic [NB-1:0][7:0]  frm_data
);
    localparam int PW = $clog2(NB);

    logic [PW-1:0]           pos;
    logic [NB-2:0][7:0]      part;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos       <= '0;
            part      <= '0;
            frm_valid <= 1'b0;
            frm_data  <= '0;
        end else begin
            frm_valid <= 1'b0;
            if (sync_q) begin
                pos <= '0;
            end else if (pop_valid) begin
                if (pos == PW'(NB - 1)) begin
                    frm_valid <= 1'b1;
                    frm_data  <= {pop_byte, part};
                    pos       <= '0;
                end else begin
                    part[pos] <= pop_byte;
                    pos       <= pos + 1'b1;
                end
            end
        end
    end

    p_sync_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |=> (pos == '0));
    p_frame_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (pos == '0));
endmodule

// File: rtl/tdf_walk.sv
module tdf_walk
    import tdf_pkg::*;
#(
    parameter int NB = FRAME_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic [NB-1:0][7:0]  frm_data,
    input  logic [ID_W-1:0]     stream_sel,
    output logic                out_valid,
    output logic [7:0]          out_byte,
    output logic [ID_W-1:0]     cur_id
);
    localparam int IW   = $clog2(NB);
    localparam int LAST = NB - 2;

    walk_state_e     st, st_nx;
    logic [IW-1:0]   idx;
    logic [7:0]      cur_b, aux;
    logic            aux_bit, is_id, match, pend;
    logic [ID_W-1:0] pend_id;

    assign cur_b   = frm_data[idx];
    assign aux     = frm_data[NB-1];
    assign aux_bit = aux[idx[IW-1:1]];
    assign is_id   = cur_b[0];
    assign match   = (cur_id == stream_sel) && (cur_id != '0);

    always_comb begin
        st_nx = st;
        unique case (st)
            W_IDLE:  if (frm_valid) st_nx = W_EVEN;
            W_EVEN:  st_nx = (idx == IW'(LAST)) ? W_IDLE : W_ODD;
            W_ODD:   st_nx = W_EVEN;
            default: st_nx = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= W_IDLE;
            idx <= '0;
        end else begin
            st  <= st_nx;
            idx <= (st == W_IDLE) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            cur_id    <= '0;
            pend      <= 1'b0;
            pend_id   <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (st)
                W_EVEN: begin
                    if (is_id) begin
                        if (aux_bit && idx != IW'(LAST)) begin
                            pend    <= 1'b1;
                            pend_id <= cur_b[7:1];
                        end else begin
                            cur_id <= cur_b[7:1];
                        end
                    end else if (match) begin
                        out_valid <= 1'b1;
                        out_byte  <= {cur_b[7:1], aux_bit};
                    end
                end
                W_ODD: begin
                    if (match) begin
                        out_valid <= 1'b1;
                        out_byte  <= cur_b;
                    end
                    if (pend) begin
                        cur_id <= pend_id;
                        pend   <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    p_frame_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (st == W_IDLE));
    p_deferred_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_ODD && pend) |=> (cur_id == $past(pend_id)));
    p_emit_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(cur_id) == $past(stream_sel) && $past(cur_id) != '0));
endmodule

// File: rtl/trace_deformatter.sv
module trace_deformatter
    import tdf_pkg::*;
#(
    parameter int SKIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [SKIP_W-1:0] skip_count,
    input  logic [ID_W-1:0]   stream_sel,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic [ID_W-1:0]   cur_stream
);
    logic                          pop_valid, sync_q, frm_valid;
    logic [7:0]                    pop_byte;
    logic [FRAME_BYTES-1:0][7:0]   frm_data;

    tdf_align #(.SKIP_W(SKIP_W)) u_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .skip_count(skip_count), .pop_valid(pop_valid), .pop_byte(pop_byte),
        .sync_q(sync_q)
    );

    tdf_frame #(.NB(FRAME_BYTES)) u_frame (
        .clk(clk), .rst_n(rst_n), .pop_valid(pop_valid), .pop_byte(pop_byte),
        .sync_q(sync_q), .frm_valid(frm_valid), .frm_data(frm_data)
    );

    tdf_walk #(.NB(FRAME_BYTES)) u_walk (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
        .stream_sel(stream_sel), .out_valid(out_valid), .out_byte(out_byte),
        .cur_id(cur_stream)
    );

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && cur_stream == '0));
endmodule

// File: tb/trace_deformatter_bench.sv
module trace_deformatter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic [7:0] skip_count = 8'd3;
    logic [6:0] stream_sel = 7'd1;
    logic       out_valid;
    logic [7:0] out_byte;
    logic [6:0] cur_stream;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [6:0] m_id = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    trace_deformatter u_trace_deformatter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .skip_count(skip_count), .stream_sel(stream_sel),
        .out_valid(out_valid), .out_byte(out_byte), .cur_stream(cur_stream)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares every produced byte against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R10 unexpected output byte", out_byte, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_byte == e, t, out_byte, e);
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_sync();
        send_byte(8'hFF); send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h7F);
    endtask

    // reference: decode per requirements R5..R10 and push expected bytes
    task automatic send_frame(input logic [7:0] f[16]);
        logic       pend;
        logic [6:0] pid;
        pend = 1'b0;
        pid  = '0;
        for (int p = 0; p < 15; p++) begin
            logic ab;
            ab = f[15][p/2];
            if (p % 2 == 0) begin
                if (f[p][0]) begin
                    if (ab && p != 14) begin pend = 1'b1; pid = f[p][7:1]; end
                    else m_id = f[p][7:1];
                end else if (m_id == stream_sel && m_id != 0) begin
                    exp_q.push_back({f[p][7:1], ab});
                    tag_q.push_back($sformatf("R7 even data pos %0d", p));
                end
            end else begin
                if (m_id == stream_sel && m_id != 0) begin
                    exp_q.push_back(f[p]);
                    tag_q.push_back($sformatf("R9 odd data pos %0d", p));
                end
                if (pend) begin m_id = pid; pend = 1'b0; end
            end
        end
        for (int p = 0; p < 16; p++) send_byte(f[p]);
    endtask

    function automatic void fill(ref logic [7:0] f[16], input logic [7:0] seed, input logic [7:0] aux);
        for (int i = 0; i < 15; i++)
            f[i] = (i % 2 == 0) ? ((seed + 8'(i) * 8'h11) & 8'hFE)
                                : ((seed + 8'(i) * 8'h13) & 8'h7F);
        f[15] = aux;
    endfunction

    initial begin
        logic [7:0] f[16];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(cur_stream == 7'd0, "R1 cur_stream after reset", cur_stream, 0);

        // R2: three ID-like bytes skipped; misalignment would emit bytes
        send_byte(8'h03); send_byte(8'h05); send_byte(8'h07);
        fill(f, 8'h20, 8'h5A);               // no IDs: ID 0, nothing out (R10)
        send_frame(f);
        // R6/R7: ID 1 immediate at pos 0, aux restores LSBs
        fill(f, 8'h31, 8'hAA); f[0] = 8'h03;
        send_frame(f);
        // R8: deferred ID 2 at pos 0, immediate ID 1 at pos 6, deferred 2 at pos 14
        fill(f, 8'h42, 8'h81); f[0] = 8'h05; f[6] = 8'h03; f[14] = 8'h05;
        send_frame(f);
        // under ID 2; deferred return to ID 1 at pos 8
        fill(f, 8'h53, 8'h7E); f[8] = 8'h03; f[15] = 8'h7E | 8'h10;
        send_frame(f);
        // R3: partial frame with an ID byte discarded by sync
        send_byte(8'h05); send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        send_sync();
        // R4: sync straddling the frame boundary after 14 bytes
        for (int i = 0; i < 14; i++) send_byte(8'(8'h05 + i * 2));
        send_sync();
        fill(f, 8'h64, 8'h3C);
        send_frame(f);
        send_sync();
        idle(60);
        check(exp_q.size() == 0, "R10 all expected bytes produced", exp_q.size(), 0);
        check(cur_stream == m_id, "R8 current stream at end", cur_stream, m_id);
        check(out_valid == 1'b0, "R4 quiet after sync flush", out_valid, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule